// File: doc/BRIEF.md
# MSI capability register file

This block holds the registers of a message-signalled-interrupt capability that sits at a fixed place in a device's configuration space. Build-time parameters set the base offset of the capability, the number of vectors the function can raise (a power of two from 1 to 32), whether the message address is 64 bits wide, and whether per-vector masking exists. These options change both the size of the capability window and where the data, mask and pending registers fall inside it.

Configuration accesses arrive one dword at a time on a valid/ready request channel with per-byte enables. Writes that land on a register pass through that register's write mask. Reads return on a separate valid/ready response channel one cycle after acceptance. A response that the consumer does not take stays valid and stable, and the request channel stalls (`cfg_ready` low) until the consumer takes it. Writes produce no response. The programmed fields leave the block as plain outputs for the interrupt delivery logic: enable, allocated vector count, message address, message data and mask bits. A strobe tells the legacy line interrupt logic to release its pin while the capability is enabled.

Top module: `msi_cap_regs`

## Requirements
- R1: Reset clears the enable bit, the enabled-vector field, both address registers, the data register and the mask register. After reset the control dword (dword 0 of the window) reads `{7'b0, mask_capable, is_64bit, enabled_log2[2:0], capable_log2[2:0], enable}` in bits 31:16, with zero in bits 15:0. With default parameters this value is 0x0186_0000.
- R2: In the control word, only the enable bit (dword bit 16) and the enabled-vector field (bits 22:20) accept writes, and only when byte enable 2 is set. The capable-count field and the two feature flags are read-only.
- R3: A control write with the enable bit set that requests an enabled-vector value above the capable value stores the capable value instead. A write with the enable bit clear stores the requested value unchanged. While enabled, `vec_alloc_log2` never exceeds the capable value.
- R4: The low address register (dword 1) writes per byte and always reads bits 1:0 as zero.
- R5: In 64-bit mode the high address register (dword 2) accepts writes in all 32 bits. `msg_addr` is `{high, low}`, and its upper half is zero in 32-bit mode.
- R6: The data register is 16 bits wide, written through byte enables 1:0. It sits at dword 3 in 64-bit mode and at dword 2 in 32-bit mode. Bits 31:16 of its dword read as zero.
- R7: The mask register (dword 4 in 64-bit mode, dword 3 otherwise; present only with masking) has writable bits 0 to N-1, where N is the capable count. All higher bits read as zero.
- R8: The pending dword (one dword above the mask) reads `pend_bits` with bits N and above forced to zero. Writes to it change nothing.
- R9: Reads outside the window, and reads of unused bits inside it, return zero. Writes outside the window change no register.
- R10: `intx_deassert` is high exactly while `msi_enable` is high.
- R11: A request is accepted when `cfg_valid` and `cfg_ready` are both high, and `cfg_ready` is low only while a response is held unaccepted. An accepted read makes `rsp_valid` high on the next cycle. The response stays valid and stable until `rsp_ready` is high. An accepted write leaves `rsp_valid` low on the next cycle.
- R12: The register outputs change only in the cycle after an accepted write, and they show that write from that cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration request valid |
| cfg_ready | output | 1 | Request can be accepted |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 6 | Dword index into configuration space |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data |
| pend_bits | input | 32 | Pending flags from delivery logic |
| msi_enable | output | 1 | Capability enabled |
| vec_alloc_log2 | output | 3 | Enabled vector count, base-2 log |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask bits |
| intx_deassert | output | 1 | Request to release the legacy interrupt pin |

## Verification
The control word gets a request above the capable count twice: once with enable clear and once with it set. The two readbacks must differ, which separates store-as-written from clamping. Byte-enable patterns of all ones, a single low byte, and a set that leaves out byte 2 tell per-byte merging apart from whole-dword writes and show that the control field is gated on its own lane. All-ones writes to the address, data, mask and pending dwords show which bits each write mask keeps. Accesses just below and just above the window, a stalled response, and a second reset after programming show decode limits, back-pressure and reset defaults.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_ALO,
    SEL_AHI,
    SEL_DATA,
    SEL_MASK,
    SEL_PEND
  } reg_sel_e;

  // window length in bytes for each option pair
  function automatic int unsigned win_bytes(input bit is64, input bit has_mask);
    if (has_mask) return is64 ? 24 : 20;
    return is64 ? 14 : 10;
  endfunction

  // dword positions that move with the address width
  function automatic logic [5:0] data_dw(input bit is64);
    return is64 ? 6'd3 : 6'd2;
  endfunction

  function automatic logic [5:0] mask_dw(input bit is64);
    return is64 ? 6'd4 : 6'd3;
  endfunction

  function automatic logic [5:0] pend_dw(input bit is64);
    return is64 ? 6'd5 : 6'd4;
  endfunction

  function automatic logic [31:0] low_ones(input int n);
    if (n >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << n) - 32'd1;
  endfunction

  // byte-lane write with a per-bit writable mask
  function automatic logic [31:0] merge_bytes(input logic [31:0] cur,
                                              input logic [31:0] wd,
                                              input logic [3:0]  be,
                                              input logic [31:0] wm);
    logic [31:0] r;
    r = cur;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) begin
        r[8*b +: 8] = (cur[8*b +: 8] & ~wm[8*b +: 8]) | (wd[8*b +: 8] & wm[8*b +: 8]);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter logic [7:0] CAP_BASE = 8'h50,
  parameter bit         ADDR64   = 1'b1,
  parameter bit         PVM      = 1'b1
) (
  input  logic [5:0] addr_dw,
  output reg_sel_e   sel
);
  localparam logic [5:0]  BASE_DW = CAP_BASE[7:2];
  localparam int unsigned WIN     = win_bytes(ADDR64, PVM);
  localparam logic [5:0]  DATA_DW = data_dw(ADDR64);
  localparam logic [5:0]  MASK_DW = mask_dw(ADDR64);
  localparam logic [5:0]  PEND_DW = pend_dw(ADDR64);

  logic [5:0] rel;
  logic       in_win;

  assign rel    = addr_dw - BASE_DW;
  assign in_win = (addr_dw >= BASE_DW) && ((int'(rel) * 4) < int'(WIN));

  always_comb begin
    sel = SEL_NONE;
    if (in_win) begin
      if (rel == 6'd0)                 sel = SEL_CTRL;
      else if (rel == 6'd1)            sel = SEL_ALO;
      else if (ADDR64 && rel == 6'd2)  sel = SEL_AHI;
      else if (rel == DATA_DW)         sel = SEL_DATA;
      else if (PVM && rel == MASK_DW)  sel = SEL_MASK;
      else if (PVM && rel == PEND_DW)  sel = SEL_PEND;
      else                             sel = SEL_NONE;
    end
  end
endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl #(
  parameter int VEC_LOG2 = 3,
  parameter bit ADDR64   = 1'b1,
  parameter bit PVM      = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_enable_bit,
  input  logic [2:0]  wr_mme,
  output logic        enable,
  output logic [2:0]  mme,
  output logic [15:0] rd_word
);
  localparam logic [2:0] CAP = 3'(VEC_LOG2);

  logic       en_q;
  logic [2:0] mme_q;
  logic [2:0] mme_nx;

  // an oversized request is cut back to the capable count once enabled
  always_comb begin
    mme_nx = wr_mme;
    if (wr_enable_bit && (wr_mme > CAP)) mme_nx = CAP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      mme_q <= 3'd0;
    end else if (wr_en) begin
      en_q  <= wr_enable_bit;
      mme_q <= mme_nx;
    end
  end

  assign enable  = en_q;
  assign mme     = mme_q;
  assign rd_word = {7'd0, PVM, ADDR64, mme_q, CAP, en_q};
endmodule

// File: rtl/msi_cap_msg.sv
module msi_cap_msg
  import msi_cap_pkg::*;
#(
  parameter int VEC_LOG2 = 3,
  parameter bit ADDR64   = 1'b1,
  parameter bit PVM      = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_alo,
  input  logic        we_ahi,
  input  logic        we_data,
  input  logic        we_mask,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] addr_lo,
  output logic [31:0] addr_hi,
  output logic [15:0] data,
  output logic [31:0] mask
);
  localparam int          NVEC      = 1 << VEC_LOG2;
  localparam logic [31:0] ALO_WMASK = 32'hFFFF_FFFC;
  localparam logic [31:0] MSK_WMASK = low_ones(NVEC);

  logic [31:0] alo_q;
  logic [15:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      alo_q <= 32'd0;
    else if (we_alo) alo_q <= merge_bytes(alo_q, wdata, be, ALO_WMASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= 16'd0;
    end else if (we_data) begin
      for (int b = 0; b < 2; b++) begin
        if (be[b]) data_q[8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  generate
    if (ADDR64) begin : g_hi
      logic [31:0] ahi_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      ahi_q <= 32'd0;
        else if (we_ahi) ahi_q <= merge_bytes(ahi_q, wdata, be, 32'hFFFF_FFFF);
      end
      assign addr_hi = ahi_q;
    end else begin : g_no_hi
      logic unused_hi;
      assign unused_hi = we_ahi;
      assign addr_hi   = 32'd0;
    end

    if (PVM) begin : g_mask
      logic [31:0] msk_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       msk_q <= 32'd0;
        else if (we_mask) msk_q <= merge_bytes(msk_q, wdata, be, MSK_WMASK);
      end
      assign mask = msk_q;
    end else begin : g_no_mask
      logic unused_mask;
      assign unused_mask = we_mask;
      assign mask        = 32'd0;
    end
  endgenerate

  assign addr_lo = alo_q;
  assign data    = data_q;
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter logic [7:0] CAP_BASE = 8'h50,
  parameter int         VEC_LOG2 = 3,
  parameter bit         ADDR64   = 1'b1,
  parameter bit         PVM      = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  output logic        cfg_ready,
  input  logic        cfg_write,
  input  logic [5:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  input  logic [31:0] pend_bits,
  output logic        msi_enable,
  output logic [2:0]  vec_alloc_log2,
  output logic [63:0] msg_addr,
  output logic [15:0] msg_data,
  output logic [31:0] vec_mask,
  output logic        intx_deassert
);
  localparam int          NVEC      = 1 << VEC_LOG2;
  localparam logic [31:0] PEND_KEEP = low_ones(NVEC);

  reg_sel_e    sel;
  logic        acc, wr_acc;
  logic [15:0] ctrl_word;
  logic [31:0] addr_lo, addr_hi, mask;
  logic [15:0] data;
  logic [31:0] rd_mux;

  assign cfg_ready = !rsp_valid || rsp_ready;
  assign acc       = cfg_valid && cfg_ready;
  assign wr_acc    = acc && cfg_write;

  msi_cap_decode #(.CAP_BASE(CAP_BASE), .ADDR64(ADDR64), .PVM(PVM)) u_dec (
    .addr_dw (cfg_addr),
    .sel     (sel)
  );

  msi_cap_ctrl #(.VEC_LOG2(VEC_LOG2), .ADDR64(ADDR64), .PVM(PVM)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_acc && (sel == SEL_CTRL) && cfg_be[2]),
    .wr_enable_bit (cfg_wdata[16]),
    .wr_mme        (cfg_wdata[22:20]),
    .enable        (msi_enable),
    .mme           (vec_alloc_log2),
    .rd_word       (ctrl_word)
  );

  msi_cap_msg #(.VEC_LOG2(VEC_LOG2), .ADDR64(ADDR64), .PVM(PVM)) u_msg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_alo  (wr_acc && (sel == SEL_ALO)),
    .we_ahi  (wr_acc && (sel == SEL_AHI)),
    .we_data (wr_acc && (sel == SEL_DATA)),
    .we_mask (wr_acc && (sel == SEL_MASK)),
    .be      (cfg_be),
    .wdata   (cfg_wdata),
    .addr_lo (addr_lo),
    .addr_hi (addr_hi),
    .data    (data),
    .mask    (mask)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = {ctrl_word, 16'd0};
      SEL_ALO:  rd_mux = addr_lo;
      SEL_AHI:  rd_mux = addr_hi;
      SEL_DATA: rd_mux = {16'd0, data};
      SEL_MASK: rd_mux = mask;
      SEL_PEND: rd_mux = pend_bits & PEND_KEEP;
      default:  rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'd0;
    end else if (acc && !cfg_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign msg_addr      = {addr_hi, addr_lo};
  assign msg_data      = data;
  assign vec_mask      = mask;
  assign intx_deassert = msi_enable;
endmodule

// File: rtl/msi_cap_regs_chk.sv
module msi_cap_regs_chk #(
  parameter int VEC_LOG2 = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic        cfg_write,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        msi_enable,
  input logic        intx_deassert,
  input logic [2:0]  vec_alloc_log2,
  input logic [63:0] msg_addr,
  input logic [15:0] msg_data,
  input logic [31:0] vec_mask
);
  localparam int NVEC = 1 << VEC_LOG2;

  assert_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_enable |-> (vec_alloc_log2 <= 3'(VEC_LOG2)));

  assert_addr_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_addr[1:0] == 2'b00);

  assert_mask_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (64'(vec_mask) >> NVEC) == 64'd0);

  assert_intx_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_enable) |-> intx_deassert);

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cfg_ready);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_read_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && !cfg_write) |=> rsp_valid);

  assert_write_norsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && cfg_write) |=> !rsp_valid);

  assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_ready && cfg_write) |=>
      ($stable(msg_addr) && $stable(msg_data) && $stable(vec_mask) && $stable(msi_enable)));
endmodule

bind msi_cap_regs msi_cap_regs_chk #(.VEC_LOG2(VEC_LOG2)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_valid      (cfg_valid),
  .cfg_ready      (cfg_ready),
  .cfg_write      (cfg_write),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_rdata      (rsp_rdata),
  .msi_enable     (msi_enable),
  .intx_deassert  (intx_deassert),
  .vec_alloc_log2 (vec_alloc_log2),
  .msg_addr       (msg_addr),
  .msg_data       (msg_data),
  .vec_mask       (vec_mask)
);

// File: tb/msi_cap_regs_tb_top.sv
module msi_cap_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  // default build: base 0x50, 8 vectors, 64-bit, masking
  localparam logic [5:0] DW_CTRL = 6'h14;
  localparam logic [5:0] DW_ALO  = 6'h15;
  localparam logic [5:0] DW_AHI  = 6'h16;
  localparam logic [5:0] DW_DATA = 6'h17;
  localparam logic [5:0] DW_MASK = 6'h18;
  localparam logic [5:0] DW_PEND = 6'h19;
  localparam logic [5:0] DW_ABOVE = 6'h1A;
  localparam logic [5:0] DW_BELOW = 6'h13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic        cfg_write = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [31:0] pend_bits = '0;
  logic        msi_enable;
  logic [2:0]  vec_alloc_log2;
  logic [63:0] msg_addr;
  logic [15:0] msg_data;
  logic [31:0] vec_mask;
  logic        intx_deassert;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_cap_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pend_bits(pend_bits), .msi_enable(msi_enable), .vec_alloc_log2(vec_alloc_log2),
    .msg_addr(msg_addr), .msg_data(msg_data), .vec_mask(vec_mask),
    .intx_deassert(intx_deassert)
  );

  function automatic logic [31:0] ctrl_val(input logic en, input logic [2:0] mme);
    return {7'd0, 1'b1, 1'b1, mme, 3'd3, en, 16'd0};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected response: actual %h expected none", rsp_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, 64'(rsp_rdata), 64'(e));
      end
    end
  end

  task automatic xfer(input logic wr, input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = wr; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    while (!cfg_ready) @(negedge clk);
    @(posedge clk);
    #1;
    cfg_valid = 1'b0; cfg_write = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    xfer(1'b1, a, d, be);
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    xfer(1'b0, a, 32'd0, 4'h0);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " enable"}, 64'(msi_enable), 64'd0);
    chk({tag, " intx"}, 64'(intx_deassert), 64'd0);
    chk({tag, " mme"}, 64'(vec_alloc_log2), 64'd0);
    chk({tag, " addr"}, msg_addr, 64'd0);
    chk({tag, " data"}, 64'(msg_data), 64'd0);
    chk({tag, " mask"}, 64'(vec_mask), 64'd0);
    rd(DW_CTRL, 32'h0186_0000, {tag, " ctrl read"});
    drain();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_reset_state("R1 first reset");
    chk("R11 idle ready", 64'(cfg_ready), 64'd1);

    // R3: oversized request while disabled is kept
    wr(DW_CTRL, 32'h0070_0000, 4'b0100);
    rd(DW_CTRL, ctrl_val(1'b0, 3'd7), "R3 stored while disabled");
    drain();
    chk("R10 intx low while disabled", 64'(intx_deassert), 64'd0);

    // R3: oversized request with enable is clamped
    wr(DW_CTRL, 32'h0071_0000, 4'b0100);
    chk("R3 clamped output", 64'(vec_alloc_log2), 64'd3);
    chk("R10 enable high", 64'(msi_enable), 64'd1);
    chk("R10 intx high", 64'(intx_deassert), 64'd1);
    rd(DW_CTRL, ctrl_val(1'b1, 3'd3), "R3 clamped read");

    // R2: no byte 2 -> control unchanged; read-only fields hold
    wr(DW_CTRL, 32'hFFFF_FFFF, 4'b1011);
    rd(DW_CTRL, ctrl_val(1'b1, 3'd3), "R2 lane 2 gates control");
    wr(DW_CTRL, 32'hFE00_0021, 4'b1111);
    rd(DW_CTRL, ctrl_val(1'b0, 3'd0), "R2 read-only fields kept");
    drain();
    chk("R10 intx after disable", 64'(intx_deassert), 64'd0);
    wr(DW_CTRL, 32'h0021_0000, 4'b0100);
    chk("R2 legal mme", 64'(vec_alloc_log2), 64'd2);
    rd(DW_CTRL, ctrl_val(1'b1, 3'd2), "R2 enable with mme 2");

    // R4 low address
    wr(DW_ALO, 32'hFFFF_FFFF, 4'b1111);
    chk("R4 addr lo output", msg_addr, 64'h0000_0000_FFFF_FFFC);
    wr(DW_ALO, 32'h1234_5678, 4'b0001);
    rd(DW_ALO, 32'hFFFF_FF78, "R4 byte write low address");

    // R5 high address
    wr(DW_AHI, 32'hA5A5_5A5B, 4'b1111);
    chk("R5 msg_addr", msg_addr, 64'hA5A5_5A5B_FFFF_FF78);
    rd(DW_AHI, 32'hA5A5_5A5B, "R5 high address read");

    // R6 data
    wr(DW_DATA, 32'hDEAD_BEEF, 4'b1111);
    chk("R6 msg_data", 64'(msg_data), 64'h0000_BEEF);
    wr(DW_DATA, 32'h0000_1100, 4'b0010);
    rd(DW_DATA, 32'h0000_11EF, "R6 data read upper zero");

    // R7 mask
    wr(DW_MASK, 32'hFFFF_FFFF, 4'b1111);
    chk("R7 mask output", 64'(vec_mask), 64'h0000_00FF);
    rd(DW_MASK, 32'h0000_00FF, "R7 mask read");
    wr(DW_MASK, 32'h0000_00A5, 4'b0001);
    chk("R7 mask byte write", 64'(vec_mask), 64'h0000_00A5);

    // R8 pending
    pend_bits = 32'hFFFF_FF5A;
    rd(DW_PEND, 32'h0000_005A, "R8 pending read");
    wr(DW_PEND, 32'hFFFF_FFFF, 4'b1111);
    rd(DW_PEND, 32'h0000_005A, "R8 pending write ignored");
    drain();
    chk("R8 mask untouched by pending write", 64'(vec_mask), 64'h0000_00A5);

    // R9 outside the window
    wr(DW_ABOVE, 32'hFFFF_FFFF, 4'b1111);
    wr(DW_BELOW, 32'hFFFF_FFFF, 4'b1111);
    rd(DW_ABOVE, 32'h0, "R9 read above window");
    rd(DW_BELOW, 32'h0, "R9 read below window");
    drain();
    chk("R9 addr unchanged", msg_addr, 64'hA5A5_5A5B_FFFF_FF78);
    chk("R9 data unchanged", 64'(msg_data), 64'h0000_11EF);
    chk("R9 mask unchanged", 64'(vec_mask), 64'h0000_00A5);
    chk("R9 enable unchanged", 64'(msi_enable), 64'd1);

    // R11 back-pressure
    rsp_ready = 1'b0;
    rd(DW_ALO, 32'hFFFF_FF78, "R11 stalled response");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 valid held", 64'(rsp_valid), 64'd1);
      chk("R11 ready low", 64'(cfg_ready), 64'd0);
      chk("R11 data held", 64'(rsp_rdata), 64'hFFFF_FF78);
    end
    rsp_ready = 1'b1;
    drain();
    wr(DW_DATA, 32'h0000_0042, 4'b0001);
    chk("R11 no write response", 64'(rsp_valid), 64'd0);
    chk("R12 data after write", 64'(msg_data), 64'h0000_1142);

    // R1 second reset after programming
    do_reset();
    check_reset_state("R1 second reset");

    drain();
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11 missing responses: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule